// File: doc/BRIEF.md
# Splittable Auto-Reload Timer

This block is a timer whose counter can run as one 16-bit auto-reload counter or as two separate 8-bit auto-reload counters, a low half and a high half. Each half has its own reload value and its own sticky overflow flag. A half either advances on every system clock or on one of three external tick pulses chosen by a shared select field. A shared interrupt line is raised from the high overflow flag and, when enabled, also from the low overflow flag.

Software reaches the block through a simple register port: a write strobe with address and data, and a read-data output that is registered and follows the address with one cycle of latency. External tick sources arrive as single-cycle enable pulses that are synchronous to the system clock.

Top module: `split_timer`

## Requirements
- R1: After synchronous reset every register reads 0x00, `bus_rdata` is 0x00 and `irq` is 0.
- R2: Registers by address: 0 control (bit0 run, bit1 split, bit2 low-interrupt enable, bit3 interrupt enable, bit4 capture enable, bit6 low flag, bit7 high flag), 1 tick mode (bits1:0 external select, bit2 low half on system clock, bit3 high half on system clock), 2 low count, 3 high count, 4 low reload, 5 high reload. A write takes effect at the clock edge where `bus_wr` is high. `bus_rdata` shows the addressed register one clock edge after the address is presented.
- R3: In split mode the low half counts on each of its ticks whatever the run bit holds. On a tick at 0xFF it loads the low reload value and sets the low flag on the same edge.
- R4: In split mode the high half counts on its ticks only while the run bit is 1. On a tick at 0xFF it loads the high reload value and sets the high flag on the same edge.
- R5: A half with its system-clock bit at 1 counts on every clock. Otherwise the external select picks its tick: 00 `tick_div12`, 01 `tick_rtc`, 10 no tick at all, 11 `tick_cmp`.
- R6: With split at 0, the two halves form one 16-bit counter. It is gated by run and driven by the low half's tick source. It carries from low to high, and on a tick at 0xFFFF it loads {high reload, low reload} and sets the high flag. The low flag is left unchanged.
- R7: Overflow flags are never cleared by hardware. A control write replaces them with data bits 6 and 7. An overflow on the same edge as a clearing write leaves the flag set.
- R8: `irq` equals (interrupt enable AND high flag) OR (interrupt enable AND low-interrupt enable AND low flag). It changes on the same edge as the flags and enables it depends on.
- R9: A write to a count register on the same edge as a tick for that half loads the written value, and no count is applied.
- R10: The capture-enable bit is stored and read back but has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Registered read data of the addressed register |
| tick_div12 | input | 1 | Tick pulse, system clock divided by 12 |
| tick_rtc | input | 1 | Tick pulse, real-time clock divided by 8 |
| tick_cmp | input | 1 | Tick pulse from the comparator output |
| irq | output | 1 | Level-sensitive combined interrupt request |

## Verification
Two events can land on the same edge: a software write that clears the high flag, and a hardware overflow of the high half that sets it. A separate collision pairs a write to a count register with a tick for that half. The bench provokes both by driving the write strobe and the comparator tick in the same cycle, with the high count preset to 0xFF or the low count targeted. It then judges the result by reading back the control register and the count. The flag must remain set, and the written count must win with no increment on top.

// File: rtl/st_pkg.sv
package st_pkg;
  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_MODE   = 3'd1,
    A_CNT_LO = 3'd2,
    A_CNT_HI = 3'd3,
    A_RLD_LO = 3'd4,
    A_RLD_HI = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {
    EXT_DIV12 = 2'b00,
    EXT_RTC   = 2'b01,
    EXT_RSVD  = 2'b10,
    EXT_CMP   = 2'b11
  } ext_src_e;

  localparam int B_RUN    = 0;
  localparam int B_SPLIT  = 1;
  localparam int B_LOIEN  = 2;
  localparam int B_IEN    = 3;
  localparam int B_CAP    = 4;
  localparam int B_FLO    = 6;
  localparam int B_FHI    = 7;
  localparam int B_LOSYS  = 2;
  localparam int B_HISYS  = 3;
endpackage

// File: rtl/st_tick_sel.sv
module st_tick_sel
  import st_pkg::*;
(
  input  logic       sys_sel,
  input  logic [1:0] ext_sel,
  input  logic       tick_div12,
  input  logic       tick_rtc,
  input  logic       tick_cmp,
  output logic       tick
);
  always_comb begin
    if (sys_sel) begin
      tick = 1'b1;
    end else begin
      unique case (ext_src_e'(ext_sel))
        EXT_DIV12: tick = tick_div12;
        EXT_RTC:   tick = tick_rtc;
        EXT_CMP:   tick = tick_cmp;
        default:   tick = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/st_half.sv
module st_half #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         inc,
  input  logic         reload,
  input  logic [W-1:0] rld_val,
  output logic [W-1:0] cnt,
  output logic         at_max
);
  localparam logic [W-1:0] ALL_ONES = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (wr) begin
      cnt <= wdata;
    end else if (inc) begin
      cnt <= reload ? rld_val : cnt + 1'b1;
    end
  end

  assign at_max = (cnt == ALL_ONES);

  AST_RELOAD_LOAD: assert property (@(posedge clk) disable iff (rst)
    (inc && reload && !wr) |=> (cnt == $past(rld_val))); // R3
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    wr |=> (cnt == $past(wdata))); // R9
endmodule

// File: rtl/split_timer.sv
module split_timer
  import st_pkg::*;
#(
  parameter int HW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [HW-1:0] bus_wdata,
  output logic [HW-1:0] bus_rdata,
  input  logic          tick_div12,
  input  logic          tick_rtc,
  input  logic          tick_cmp,
  output logic          irq
);
  localparam int NH = 2;

  logic run_q, split_q, lo_ien_q, ien_q, cap_q, flag_lo_q, flag_hi_q;
  logic [1:0] ext_sel_q;
  logic [NH-1:0] sys_q;
  logic [HW-1:0] rld_q [NH];
  logic [HW-1:0] cnt [NH];
  logic [NH-1:0] at_max, inc, reload, wr_cnt, tick;
  logic ov_lo, ov_hi, ctrl_wr, mode_wr;
  logic fl_n, fh_n, ien_n, lo_ien_n;
  logic irq_q;

  assign ctrl_wr   = bus_wr && (bus_addr == AW'(A_CTRL));
  assign mode_wr   = bus_wr && (bus_addr == AW'(A_MODE));
  assign wr_cnt[0] = bus_wr && (bus_addr == AW'(A_CNT_LO));
  assign wr_cnt[1] = bus_wr && (bus_addr == AW'(A_CNT_HI));

  for (genvar g = 0; g < NH; g++) begin : g_half
    st_tick_sel u_sel (
      .sys_sel    (sys_q[g]),
      .ext_sel    (ext_sel_q),
      .tick_div12 (tick_div12),
      .tick_rtc   (tick_rtc),
      .tick_cmp   (tick_cmp),
      .tick       (tick[g])
    );
    st_half #(.W(HW)) u_half (
      .clk     (clk),
      .rst     (rst),
      .wr      (wr_cnt[g]),
      .wdata   (bus_wdata),
      .inc     (inc[g]),
      .reload  (reload[g]),
      .rld_val (rld_q[g]),
      .cnt     (cnt[g]),
      .at_max  (at_max[g])
    );
  end

  always_comb begin
    if (split_q) begin
      inc[0]    = tick[0];
      inc[1]    = tick[1] && run_q;
      reload[0] = at_max[0];
      reload[1] = at_max[1];
      ov_lo     = inc[0] && at_max[0] && !wr_cnt[0];
      ov_hi     = inc[1] && at_max[1] && !wr_cnt[1];
    end else begin
      inc[0]    = tick[0] && run_q;
      inc[1]    = inc[0] && at_max[0];
      reload[0] = inc[1] && at_max[1];
      reload[1] = inc[1] && at_max[1];
      ov_lo     = 1'b0;
      ov_hi     = inc[1] && at_max[1] && !wr_cnt[0] && !wr_cnt[1];
    end
  end

  assign fl_n     = (ctrl_wr ? bus_wdata[B_FLO]   : flag_lo_q) | ov_lo;
  assign fh_n     = (ctrl_wr ? bus_wdata[B_FHI]   : flag_hi_q) | ov_hi;
  assign ien_n    = ctrl_wr ? bus_wdata[B_IEN]   : ien_q;
  assign lo_ien_n = ctrl_wr ? bus_wdata[B_LOIEN] : lo_ien_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0; split_q <= 1'b0; cap_q <= 1'b0;
      lo_ien_q <= 1'b0; ien_q <= 1'b0;
      flag_lo_q <= 1'b0; flag_hi_q <= 1'b0;
      ext_sel_q <= '0; sys_q <= '0;
      rld_q[0] <= '0; rld_q[1] <= '0;
      irq_q <= 1'b0;
    end else begin
      flag_lo_q <= fl_n;
      flag_hi_q <= fh_n;
      ien_q     <= ien_n;
      lo_ien_q  <= lo_ien_n;
      irq_q     <= ien_n && (fh_n || (lo_ien_n && fl_n));
      if (ctrl_wr) begin
        run_q   <= bus_wdata[B_RUN];
        split_q <= bus_wdata[B_SPLIT];
        cap_q   <= bus_wdata[B_CAP];
      end
      if (mode_wr) begin
        ext_sel_q <= bus_wdata[1:0];
        sys_q[0]  <= bus_wdata[B_LOSYS];
        sys_q[1]  <= bus_wdata[B_HISYS];
      end
      if (bus_wr && bus_addr == AW'(A_RLD_LO)) rld_q[0] <= bus_wdata;
      if (bus_wr && bus_addr == AW'(A_RLD_HI)) rld_q[1] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      unique case (bus_addr)
        AW'(A_CTRL): begin
          bus_rdata         <= '0;
          bus_rdata[B_RUN]   <= run_q;
          bus_rdata[B_SPLIT] <= split_q;
          bus_rdata[B_LOIEN] <= lo_ien_q;
          bus_rdata[B_IEN]   <= ien_q;
          bus_rdata[B_CAP]   <= cap_q;
          bus_rdata[B_FLO]   <= flag_lo_q;
          bus_rdata[B_FHI]   <= flag_hi_q;
        end
        AW'(A_MODE): begin
          bus_rdata          <= '0;
          bus_rdata[1:0]     <= ext_sel_q;
          bus_rdata[B_LOSYS] <= sys_q[0];
          bus_rdata[B_HISYS] <= sys_q[1];
        end
        AW'(A_CNT_LO): bus_rdata <= cnt[0];
        AW'(A_CNT_HI): bus_rdata <= cnt[1];
        AW'(A_RLD_LO): bus_rdata <= rld_q[0];
        AW'(A_RLD_HI): bus_rdata <= rld_q[1];
        default:       bus_rdata <= '0;
      endcase
    end
  end

  assign irq = irq_q;

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (flag_hi_q && !ctrl_wr) |=> flag_hi_q); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    ov_hi |=> flag_hi_q); // R7
  AST_IRQ_HI: assert property (@(posedge clk) disable iff (rst)
    (ien_q && flag_hi_q) |-> irq); // R8
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !ien_q |-> !irq); // R8
  AST_HI_PARKED: assert property (@(posedge clk) disable iff (rst)
    (split_q && !run_q && !wr_cnt[1]) |=> $stable(cnt[1])); // R4
  AST_RSVD_SILENT: assert property (@(posedge clk) disable iff (rst)
    (split_q && !sys_q[0] && ext_sel_q == EXT_RSVD && !wr_cnt[0])
      |=> $stable(cnt[0])); // R5
  AST_WIDE_NO_LOFLAG: assert property (@(posedge clk) disable iff (rst)
    (!split_q && !flag_lo_q && !ctrl_wr) |=> !flag_lo_q); // R6
endmodule

// File: tb/split_timer_test.sv
module split_timer_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic tick_div12 = 1'b0, tick_rtc = 1'b0, tick_cmp = 1'b0;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // scoreboard queues: kind 0 = read data, kind 1 = irq level
  bit        q_kind [$];
  logic [7:0] q_exp [$];
  string     q_tag [$];
  event      chk_ev;

  always #2.5 clk = ~clk;

  split_timer uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_div12(tick_div12), .tick_rtc(tick_rtc), .tick_cmp(tick_cmp),
    .irq(irq)
  );

  // monitor: pops expected items and compares against the outputs
  always begin
    @(chk_ev);
    while (q_exp.size() > 0) begin
      bit k; logic [7:0] e, act; string t;
      k = q_kind.pop_front(); e = q_exp.pop_front(); t = q_tag.pop_front();
      act = k ? {7'd0, irq} : bus_rdata;
      checks++;
      if (act !== e) begin
        errors++;
        $display("FAIL %s actual 0x%02h expected 0x%02h", t, act, e);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic chk_rd(input logic [2:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    #1;
    q_kind.push_back(1'b0); q_exp.push_back(e); q_tag.push_back(t);
    ->chk_ev;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    q_kind.push_back(1'b1); q_exp.push_back({7'd0, e}); q_tag.push_back(t);
    ->chk_ev;
  endtask

  // kind: 0 div12, 1 rtc, 2 cmp; n single-cycle pulses
  task automatic pulse(input int kind, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (kind == 0) tick_div12 = 1'b1;
      else if (kind == 1) tick_rtc = 1'b1;
      else tick_cmp = 1'b1;
      @(negedge clk);
      tick_div12 = 1'b0; tick_rtc = 1'b0; tick_cmp = 1'b0;
    end
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog actual timeout expected completion");
          $display("CHECKS %0d ERRORS %0d", checks, errors);
          $finish;
        end
      end
    join_none

    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 6; a++) chk_rd(3'(a), 8'h00, "R1 reset register");
    chk_irq(1'b0, "R1 reset irq");

    // R2 register write/read
    wr(3'd4, 8'h5A); wr(3'd5, 8'hC3);
    chk_rd(3'd4, 8'h5A, "R2 low reload");
    chk_rd(3'd5, 8'hC3, "R2 high reload");

    // R5 reserved select gives no ticks
    wr(3'd1, 8'h02); wr(3'd0, 8'h03); wr(3'd2, 8'h10); wr(3'd3, 8'h20);
    @(negedge clk); tick_div12 = 1; tick_rtc = 1; tick_cmp = 1;
    repeat (5) @(negedge clk);
    tick_div12 = 0; tick_rtc = 0; tick_cmp = 0;
    chk_rd(3'd2, 8'h10, "R5 reserved low");
    chk_rd(3'd3, 8'h20, "R5 reserved high");
    chk_rd(3'd1, 8'h02, "R2 mode readback");

    // R5 source 01 picks rtc only
    wr(3'd1, 8'h01);
    pulse(1, 3); pulse(0, 5);
    chk_rd(3'd2, 8'h13, "R5 rtc low");
    chk_rd(3'd3, 8'h23, "R5 rtc high");
    // R5 source 00 and 11
    wr(3'd1, 8'h00); pulse(0, 2);
    chk_rd(3'd2, 8'h15, "R5 div12 low");
    wr(3'd1, 8'h03); pulse(2, 1); pulse(1, 2);
    chk_rd(3'd3, 8'h26, "R5 cmp high");

    // R3/R4 split, run off: low free, high parked
    wr(3'd0, 8'h02); pulse(2, 4);
    chk_rd(3'd2, 8'h1A, "R3 low free-running");
    chk_rd(3'd3, 8'h26, "R4 high parked");

    // R3 low wrap with reload and flag
    wr(3'd2, 8'hFE); pulse(2, 2);
    chk_rd(3'd2, 8'h5A, "R3 low reload");
    repeat (4) @(negedge clk);
    chk_rd(3'd0, 8'h42, "R3 low flag sticky R7");
    chk_irq(1'b0, "R8 no enable");

    // R8 interrupt combinations
    wr(3'd0, 8'h4A);
    chk_irq(1'b0, "R8 low flag without low enable");
    wr(3'd0, 8'h4E);
    chk_irq(1'b1, "R8 low flag with low enable");
    wr(3'd0, 8'h0E);
    chk_irq(1'b0, "R8 after clear");
    chk_rd(3'd0, 8'h0E, "R7 software clear");

    // R4 high wrap, run on
    wr(3'd0, 8'h0B); wr(3'd3, 8'hFF); pulse(2, 1);
    chk_rd(3'd3, 8'hC3, "R4 high reload");
    chk_rd(3'd2, 8'h5B, "R3 low counted alongside");
    chk_rd(3'd0, 8'h8B, "R4 high flag");
    chk_irq(1'b1, "R8 high flag raises irq");

    // R7 set wins over simultaneous clear
    wr(3'd3, 8'hFF);
    @(negedge clk);
    bus_wr = 1; bus_addr = 3'd0; bus_wdata = 8'h0B; tick_cmp = 1;
    @(negedge clk);
    bus_wr = 0; tick_cmp = 0;
    chk_rd(3'd0, 8'h8B, "R7 set wins over clear");

    // R9 count write beats tick
    @(negedge clk);
    bus_wr = 1; bus_addr = 3'd2; bus_wdata = 8'h77; tick_cmp = 1;
    @(negedge clk);
    bus_wr = 0; tick_cmp = 0;
    chk_rd(3'd2, 8'h77, "R9 write overrides tick");

    // R6/R10 16-bit mode with capture bit set
    wr(3'd0, 8'h11); wr(3'd4, 8'h34); wr(3'd5, 8'h12);
    wr(3'd2, 8'hFF); wr(3'd3, 8'h05); pulse(2, 1);
    chk_rd(3'd2, 8'h00, "R6 carry low");
    chk_rd(3'd3, 8'h06, "R6 carry high");
    wr(3'd2, 8'hFE); wr(3'd3, 8'hFF); pulse(2, 2);
    chk_rd(3'd2, 8'h34, "R6 wide reload low");
    chk_rd(3'd3, 8'h12, "R6 wide reload high");
    chk_rd(3'd0, 8'h91, "R6 high flag only R10 capture kept");
    wr(3'd0, 8'h10); pulse(2, 3);
    chk_rd(3'd2, 8'h34, "R6 run off holds");

    // R5 system clock select: counts on every edge
    wr(3'd0, 8'h02); wr(3'd2, 8'h00);
    wr(3'd1, 8'h04); wr(3'd1, 8'h02);
    chk_rd(3'd2, 8'h02, "R5 system clock count");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule